// File: doc/BRIEF.md
# DSP Program Sequencer with Return Stack

This block holds the program counter of a small signal processor and decides, once per executed instruction, which address is fetched next. Normally the counter advances by one. When the current instruction is a jump, a 9-bit condition code selects what happens. It can load the counter from the serial-output register. It can take a conditional branch to a target inside the current 8K half. It can jump to either 8K half with a 13-bit long address. It can also call a subroutine, which saves the return address on a 16-entry stack first. A separate return strobe takes the saved address back off the stack.

The conditions come from outside the block. They are the six status flags of each of the two accumulators, the low nibble of the data pointer, the two serial acknowledge bits and the host request bit. The block does not generate any flags. The stack pointer is four bits wide and wraps with no warning, so a seventeenth nested call overwrites the oldest entry.

Top module: `dsp_pc_seq`

## Requirements
- R1: While `rst_n` is low, `pc` reads 0. Reset also clears the stack pointer and every stack entry to 0, so a return issued right after reset yields `pc` = 0.
- R2: The sequencer changes state only on a rising clock edge with `step` high. With `step` low, `pc` keeps its value. With `step` high and neither `jmp` nor `ret` high, `pc` becomes `pc`+1 modulo 2^14, so 0x3FFF is followed by 0x0000.
- R3: A taken conditional branch loads `pc` with {bit 13 of (`pc`+1), `bank`[1:0], `next_addr`[10:0]}. When `pc` is 0x1FFF, bit 13 of the target is therefore 1.
- R4: Code 0x000 loads `pc` from `so_val` without any condition.
- R5: For codes 0x080..0x0AF with bit 0 clear, bits [5:3] pick the flag index and bit 2 picks the accumulator (0 = `flags_a`, 1 = `flags_b`). Bit 1 gives the value the flag must have for the branch to be taken. Flag indices are: 0 carry, 1 zero, 2 overflow-0, 3 overflow-1, 4 sign-0, 5 sign-1.
- R6: Codes 0x0B0, 0x0B1, 0x0B2 and 0x0B3 branch when `dp_low` is 0, is not 0, is 0xF, and is not 0xF, respectively.
- R7: Codes 0x0B4/0x0B6 branch when `si_ack` is 0/1. Codes 0x0B8/0x0BA branch when `so_ack` is 0/1. Codes 0x0BC/0x0BE branch when `rqm` is 0/1.
- R8: A failed condition, or any code that R4, R5, R6, R7, R9 and R10 do not define (odd codes in the flag range, 0x0B5, 0x0BF, 0x0C0, 0x102 and so on), leaves `pc` at `pc`+1.
- R9: Code 0x100 loads `pc` with {0, `long_addr`}. Code 0x101 loads `pc` with {1, `long_addr`}.
- R10: Codes 0x140/0x141 store `pc`+1 in the stack slot at the pointer, increment the pointer, and jump as 0x100/0x101 do.
- R11: A return decrements the pointer and loads `pc` from the slot it then points to.
- R12: The pointer wraps modulo 16 in both directions. After 17 nested calls, the first return yields the 17th return address, the next 15 returns yield the 16th down to the 2nd, and the 17th return again yields the 17th address.
- R13: When `ret` and `jmp` are both high in a step, only the return is performed. The jump, including any push, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step | input | 1 | One instruction executes in this cycle |
| jmp | input | 1 | The executing instruction is a jump |
| ret | input | 1 | The executing instruction returns from a subroutine |
| br_code | input | 9 | Jump condition / kind code |
| bank | input | 2 | Bank field of an in-half branch target |
| next_addr | input | 11 | Address field of an in-half branch target |
| long_addr | input | 13 | Address within a half for long jumps and calls |
| flags_a | input | 6 | Flags of accumulator A (index map in R5) |
| flags_b | input | 6 | Flags of accumulator B |
| dp_low | input | 4 | Low nibble of the data pointer |
| si_ack | input | 1 | Serial-input acknowledge |
| so_ack | input | 1 | Serial-output acknowledge |
| rqm | input | 1 | Host request bit |
| so_val | input | 14 | Low 14 bits of the serial-output register |
| pc | output | 14 | Program counter (registered) |

## Verification
The one collision the interface allows is a return strobe together with a jump in the same step. The bench provokes it with a call code, because a wrongly taken call would both push and move the pointer. It makes two nested calls, then issues return and call together. It checks that `pc` lands on the inner return address. It then checks that one further return yields the outer return address and not the inner one again. The conditional codes are swept over every flag, accumulator, polarity and value. The accumulator and bits that are not under test are held at the opposite value, so a wrong bit selection changes the outcome.

// File: rtl/dsp_seq_pkg.sv
package dsp_seq_pkg;

    localparam int FLAG_N   = 6;
    localparam int CODE_W   = 9;

    // what the decoded jump code asks of the sequencer
    typedef enum logic [2:0] {
        JK_NONE   = 3'd0,
        JK_INBANK = 3'd1,
        JK_SERIAL = 3'd2,
        JK_LONG   = 3'd3,
        JK_CALL   = 3'd4
    } jkind_e;

endpackage

// File: rtl/dsp_seq_cond.sv
module dsp_seq_cond
    import dsp_seq_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    input  logic [FLAG_N-1:0] fl_a,
    input  logic [FLAG_N-1:0] fl_b,
    input  logic [3:0]        dp_nib,
    input  logic              si_ack,
    input  logic              so_ack,
    input  logic              rqm,
    output jkind_e            kind,
    output logic              hi_half
);
    localparam int PAD = 8 - FLAG_N;

    logic [5:0] off;
    logic [7:0] fa8, fb8;
    logic       sel, hit;

    assign off     = code[5:0];
    assign fa8     = {{PAD{1'b0}}, fl_a};
    assign fb8     = {{PAD{1'b0}}, fl_b};
    assign hi_half = code[0];

    always_comb begin
        kind = JK_NONE;
        hit  = 1'b0;
        sel  = 1'b0;
        if (code == '0) begin
            kind = JK_SERIAL;
        end else if (code[8:6] == 3'b010) begin
            if (off < 6'h30) begin
                // accumulator flag pairs: [5:3] flag, [2] acc, [1] wanted value
                if (!off[0]) begin
                    sel = off[2] ? fb8[off[5:3]] : fa8[off[5:3]];
                    hit = (sel == off[1]);
                end
            end else if (off < 6'h34) begin
                case (off[1:0])
                    2'd0:    hit = (dp_nib == 4'h0);
                    2'd1:    hit = (dp_nib != 4'h0);
                    2'd2:    hit = (dp_nib == 4'hF);
                    default: hit = (dp_nib != 4'hF);
                endcase
            end else if (!off[0]) begin
                case (off[3:2])
                    2'b01:   sel = si_ack;
                    2'b10:   sel = so_ack;
                    2'b11:   sel = rqm;
                    default: sel = 1'b0;
                endcase
                hit = (sel == off[1]);
            end
            if (hit) kind = JK_INBANK;
        end else if (code[8:1] == 8'h80) begin
            kind = JK_LONG;
        end else if (code[8:1] == 8'hA0) begin
            kind = JK_CALL;
        end
    end

endmodule

// File: rtl/dsp_seq_stack.sv
module dsp_seq_stack #(
    parameter int DEPTH = 16,
    parameter int DW    = 14,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [PW-1:0] wr_ptr,
    input  logic [DW-1:0] wr_data,
    input  logic [PW-1:0] rd_ptr,
    output logic [DW-1:0] rd_data
);
    logic [DW-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DW-1:0] slot_d;
        always_comb begin
            slot_d = slot_q[i];
            if (push && (wr_ptr == PW'(i))) slot_d = wr_data;
        end
        always_ff @(posedge clk) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d;
        end
    end

    assign rd_data = slot_q[rd_ptr];

endmodule

// File: rtl/dsp_pc_seq.sv
module dsp_pc_seq
    import dsp_seq_pkg::*;
#(
    parameter int BANK_W    = 2,
    parameter int NA_W      = 11,
    parameter int STK_DEPTH = 16,
    localparam int PC_W     = 1 + BANK_W + NA_W,
    localparam int LA_W     = PC_W - 1,
    localparam int SP_W     = $clog2(STK_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              jmp,
    input  logic              ret,
    input  logic [CODE_W-1:0] br_code,
    input  logic [BANK_W-1:0] bank,
    input  logic [NA_W-1:0]   next_addr,
    input  logic [LA_W-1:0]   long_addr,
    input  logic [FLAG_N-1:0] flags_a,
    input  logic [FLAG_N-1:0] flags_b,
    input  logic [3:0]        dp_low,
    input  logic              si_ack,
    input  logic              so_ack,
    input  logic              rqm,
    input  logic [PC_W-1:0]   so_val,
    output logic [PC_W-1:0]   pc
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic [SP_W-1:0] sp;
    } seq_t;

    seq_t            st_d, st_q;
    logic [PC_W-1:0] pc_q, pc_inc, pop_val;
    logic [SP_W-1:0] sp_q, sp_dec;
    logic            push_d;
    jkind_e          jkind;
    logic            long_hi;

    assign pc_q   = st_q.pc;
    assign sp_q   = st_q.sp;
    assign pc_inc = pc_q + 1'b1;
    assign sp_dec = sp_q - 1'b1;

    dsp_seq_cond u_cond (
        .code    (br_code),
        .fl_a    (flags_a),
        .fl_b    (flags_b),
        .dp_nib  (dp_low),
        .si_ack  (si_ack),
        .so_ack  (so_ack),
        .rqm     (rqm),
        .kind    (jkind),
        .hi_half (long_hi)
    );

    dsp_seq_stack #(.DEPTH(STK_DEPTH), .DW(PC_W)) u_stack (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push_d),
        .wr_ptr  (sp_q),
        .wr_data (pc_inc),
        .rd_ptr  (sp_dec),
        .rd_data (pop_val)
    );

    always_comb begin
        st_d   = st_q;
        push_d = 1'b0;
        if (step) begin
            st_d.pc = pc_inc;
            if (ret) begin
                // a return outranks any jump decoded in the same step
                st_d.sp = sp_dec;
                st_d.pc = pop_val;
            end else if (jmp) begin
                case (jkind)
                    JK_SERIAL: st_d.pc = so_val;
                    JK_INBANK: st_d.pc = {pc_inc[PC_W-1], bank, next_addr};
                    JK_LONG:   st_d.pc = {long_hi, long_addr};
                    JK_CALL: begin
                        st_d.pc = {long_hi, long_addr};
                        st_d.sp = sp_q + 1'b1;
                        push_d  = 1'b1;
                    end
                    default:   st_d.pc = pc_inc;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc = pc_q;

endmodule

// File: rtl/dsp_seq_chk.sv
module dsp_seq_chk
    import dsp_seq_pkg::*;
#(
    parameter int PC_W = 14,
    parameter int LA_W = 13,
    parameter int SP_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic              jmp,
    input logic              ret,
    input logic [CODE_W-1:0] br_code,
    input logic [LA_W-1:0]   long_addr,
    input logic [PC_W-1:0]   so_val,
    input logic [PC_W-1:0]   pc,
    input logic [SP_W-1:0]   sp_q,
    input jkind_e            jkind
);
    logic jump_go;
    assign jump_go = step && jmp && !ret;

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> ($stable(pc) && $stable(sp_q))); // R2

    AST_PLAIN_INC: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !jmp && !ret) |=> (pc == $past(pc) + 1'b1)); // R2

    AST_INBANK_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_go && jkind == JK_INBANK)
            |=> (pc[PC_W-1] == ($past(pc[PC_W-1]) ^ (&$past(pc[PC_W-2:0]))))); // R3

    AST_SERIAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_go && br_code == '0) |=> (pc == $past(so_val))); // R4

    AST_LONG_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_go && br_code[8:1] == 8'h80)
            |=> (pc == {$past(br_code[0]), $past(long_addr)})); // R9

    AST_CALL_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (jump_go && br_code[8:1] == 8'hA0)
            |=> (sp_q == $past(sp_q) + 1'b1 && pc == {$past(br_code[0]), $past(long_addr)})); // R10

    AST_RET_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && ret) |=> (sp_q == $past(sp_q) - 1'b1)); // R11

endmodule

bind dsp_pc_seq dsp_seq_chk #(.PC_W(PC_W), .LA_W(LA_W), .SP_W(SP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .jmp       (jmp),
    .ret       (ret),
    .br_code   (br_code),
    .long_addr (long_addr),
    .so_val    (so_val),
    .pc        (pc),
    .sp_q      (sp_q),
    .jkind     (jkind)
);

// File: tb/tb_dsp_pc_seq.sv
module tb_dsp_pc_seq;
    localparam int CLK_PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0, jmp = 1'b0, ret = 1'b0;
    logic [8:0]  code = '0;
    logic [1:0]  bank = '0;
    logic [10:0] na = '0;
    logic [12:0] la = '0;
    logic [5:0]  fa = '0, fb = '0;
    logic [3:0]  dpl = '0;
    logic        sia = 1'b0, soa = 1'b0, rqm = 1'b0;
    logic [13:0] sov = '0;
    logic [13:0] pc;

    int          nchk = 0, nerr = 0;
    logic [13:0] cur = '0;
    logic [13:0] mstk [16];
    int          msp = 0;
    bit          done = 0;

    always #(CLK_PER/2) clk = ~clk;

    dsp_pc_seq dut (
        .clk(clk), .rst_n(rst_n), .step(step), .jmp(jmp), .ret(ret),
        .br_code(code), .bank(bank), .next_addr(na), .long_addr(la),
        .flags_a(fa), .flags_b(fb), .dp_low(dpl), .si_ack(sia),
        .so_ack(soa), .rqm(rqm), .so_val(sov), .pc(pc)
    );

    task automatic chk(input string tag, input logic [13:0] act, input logic [13:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: pc=%h expected %h", tag, act, exp);
        end
    endtask

    task automatic go(input logic [13:0] exp, input string tag);
        step = 1'b1;
        @(posedge clk); @(negedge clk);
        step = 1'b0; jmp = 1'b0; ret = 1'b0;
        chk(tag, pc, exp);
        cur = exp;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step = 1'b0; jmp = 1'b0; ret = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 reset", pc, 14'h0000);
        rst_n = 1'b1;
        cur = '0; msp = 0;
        for (int i = 0; i < 16; i++) mstk[i] = '0;
    endtask

    task automatic setpc(input logic [13:0] a);
        jmp = 1'b1; code = {8'h80, a[13]}; la = a[12:0];
        go(a, "R9 long jump");
    endtask

    task automatic call(input logic [13:0] a);
        jmp = 1'b1; code = {8'hA0, a[13]}; la = a[12:0];
        mstk[msp] = cur + 14'd1; msp = (msp + 1) % 16;
        go(a, "R10 call");
    endtask

    task automatic pop(input string tag);
        ret = 1'b1;
        msp = (msp + 15) % 16;
        go(mstk[msp], tag);
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nerr++; nchk++;
        $display("FAIL watchdog: run did not complete");
        finish_up();
    end

    initial begin
        logic [13:0] e;
        @(negedge clk);
        do_reset();

        // R1: stack cleared, so immediate return yields 0
        pop("R1 pop after reset");

        // R2: hold with step low, even with a jump presented
        setpc(14'h0123);
        jmp = 1'b1; code = 9'h101; la = 13'h0777; step = 1'b0;
        @(posedge clk); @(negedge clk); jmp = 1'b0;
        chk("R2 hold", pc, 14'h0123);
        for (int i = 0; i < 3; i++) go(cur + 14'd1, "R2 increment");
        setpc(14'h3FFF);
        go(14'h0000, "R2 wrap");

        // R4: serial-out load
        sov = 14'h2ABC; jmp = 1'b1; code = 9'h000; go(14'h2ABC, "R4 serial");
        sov = 14'h0155; jmp = 1'b1; code = 9'h000; go(14'h0155, "R4 serial");

        // R3: in-bank target per bank and half, plus carry into bit 13
        fa = '0; fb = '0;
        for (int h = 0; h < 2; h++) begin
            for (int b = 0; b < 4; b++) begin
                setpc(h ? 14'h2100 : 14'h0100);
                jmp = 1'b1; code = 9'h080; bank = 2'(b); na = 11'h2A5;
                e = ((cur + 14'd1) & 14'h2000) | 14'(b << 11) | 14'h2A5;
                go(e, "R3 in-bank");
            end
        end
        setpc(14'h1FFF);
        jmp = 1'b1; code = 9'h080; bank = 2'd0; na = 11'h003;
        go(14'h2003, "R3 bit13 from incremented pc");

        // R5: full flag sweep
        for (int g = 0; g < 6; g++)
            for (int acc = 0; acc < 2; acc++)
                for (int s = 0; s < 2; s++)
                    for (int v = 0; v < 2; v++) begin
                        logic [5:0] tv;
                        setpc(14'h0200);
                        tv = v ? (6'b1 << g) : ~(6'b1 << g);
                        fa = acc ? {6{v == 0}} : tv;
                        fb = acc ? tv : {6{v == 0}};
                        jmp = 1'b1; bank = 2'd1; na = 11'h155;
                        code = 9'(9'h080 + g * 8 + acc * 4 + s * 2);
                        go((v == s) ? 14'h0955 : 14'h0201, "R5 flag branch");
                    end

        // R6: data-pointer nibble tests
        for (int c = 0; c < 4; c++)
            for (int k = 0; k < 3; k++) begin
                logic t;
                setpc(14'h0300);
                dpl = (k == 0) ? 4'h0 : (k == 1) ? 4'h5 : 4'hF;
                case (c)
                    0: t = (dpl == 4'h0);
                    1: t = (dpl != 4'h0);
                    2: t = (dpl == 4'hF);
                    default: t = (dpl != 4'hF);
                endcase
                jmp = 1'b1; code = 9'(9'h0B0 + c); bank = 2'd2; na = 11'h011;
                go(t ? 14'h1011 : 14'h0301, "R6 dp nibble");
            end

        // R7: handshake bits
        for (int w = 0; w < 3; w++)
            for (int s = 0; s < 2; s++)
                for (int v = 0; v < 2; v++) begin
                    setpc(14'h2400);
                    sia = (w == 0) ? v[0] : ~v[0];
                    soa = (w == 1) ? v[0] : ~v[0];
                    rqm = (w == 2) ? v[0] : ~v[0];
                    jmp = 1'b1; bank = 2'd3; na = 11'h7F0;
                    code = 9'(9'h0B4 + w * 4 + s * 2);
                    go((v == s) ? 14'h3FF0 : 14'h2401, "R7 handshake");
                end

        // R8: undefined codes never branch
        for (int f = 0; f < 2; f++) begin
            fa = {6{f[0]}}; fb = {6{f[0]}}; dpl = {4{f[0]}};
            sia = f[0]; soa = f[0]; rqm = f[0];
            foreach (mstk[i]) begin end
            for (int u = 0; u < 7; u++) begin
                logic [8:0] uc;
                case (u)
                    0: uc = 9'h081; 1: uc = 9'h083; 2: uc = 9'h0B5; 3: uc = 9'h0BF;
                    4: uc = 9'h0C0; 5: uc = 9'h102; default: uc = 9'h001;
                endcase
                setpc(14'h0500);
                jmp = 1'b1; code = uc; bank = 2'd3; na = 11'h7FF;
                go(14'h0501, "R8 no branch");
            end
        end

        // R10 / R11: nested calls and returns
        do_reset();
        setpc(14'h0010);
        call(14'h2500);
        call(14'h0A00);
        go(14'h0A01, "R2 increment");
        pop("R11 return");
        pop("R11 return");

        // R12: 17 nested calls then 17 returns
        do_reset();
        for (int i = 1; i <= 17; i++) call(14'(i * 14'h0123));
        for (int i = 0; i < 17; i++) pop("R12 wrap");

        // R13: return and call in the same step
        do_reset();
        setpc(14'h0040);
        call(14'h0800);
        call(14'h2900);
        jmp = 1'b1; code = 9'h141; la = 13'h1234;
        pop("R13 return wins");
        pop("R13 no push happened");

        finish_up();
    end

endmodule